// File: doc/BRIEF.md
# CSR Instruction Access Unit

This unit carries out the six atomic control-and-status-register instructions of a 32-bit RISC-V integer core. Each instruction reads a CSR and may also change it, in one of three ways: swap in a new value, set bits, or clear bits. Each has a register form and a 5-bit immediate form. The unit takes the instruction word, the value of the source register and a valid strobe. It drives a CSR access port (address, read strobe, write strobe, proposed write data, read data) and returns the previous CSR contents for writeback to the destination register.

Whether a read or a write takes place depends only on the register indices and the immediate field, never on data values. A swap whose destination is x0 performs no read. A set or clear whose source index or immediate is zero performs no write. A nonzero source register that happens to hold zero still produces a write of the unchanged value. Each access completes in a single cycle.

A small demonstration bank of four CSRs sits behind the port. Each has its own mask of writable bits, and one of them sits in the read-only address region, so the whole flow can be exercised in isolation.

Top module: `csr_access_unit`

## Requirements
- R1: An instruction is handled only when bits [6:0] are 1110011 and funct3 (bits [14:12]) is 001 swap, 010 set, 011 clear, 101 swap-immediate, 110 set-immediate or 111 clear-immediate. The CSR address is bits [31:20], the source index or immediate is bits [19:15] and the destination index is bits [11:7]. Any other word drives no strobe and raises no illegal flag.
- R2: rd_data_o carries the previous CSR value, zero-extended to 32 bits. rd_we_o is high for a legal instruction whose destination index is nonzero, and low otherwise.
- R3: The proposed write value is: the operand for a swap; the old value OR the operand for a set; the old value AND NOT the operand for a clear.
- R4: On a write, only the bits in the register's writable mask change. All other bits keep their stored value.
- R5: A swap with destination index 0 keeps csr_re_o low. Every other legal instruction raises csr_re_o.
- R6: A register-form set or clear with source index 0 keeps csr_we_o low. A nonzero source index raises csr_we_o even when the source value is zero, and the CSR then holds its previous value.
- R7: Immediate forms use the 5-bit field zero-extended to 32 bits as the operand. An immediate of zero suppresses the write for set-immediate and clear-immediate.
- R8: Addresses with bits [11:10] equal to 11 are read-only. Any instruction that would write one of them raises illegal_o. A set or clear whose write is suppressed reads such a CSR legally.
- R9: An address outside the bank raises illegal_o. An illegal instruction drives csr_re_o, csr_we_o and rd_we_o low, and the CSR keeps its value.
- R10: Outputs settle in the same cycle. A write takes effect at the rising clock edge only when valid_i is high. With valid_i low, no strobe and no illegal flag is raised.
- R11: A synchronous active-high reset loads the bank as follows: 0x300 holds 0x00000002 with writable mask 0x00001888; 0x305 holds 0x00000100 with mask 0xFFFFFFFC; 0x340 holds 0 with mask 0xFFFFFFFF; 0xC00 holds 0x12345678 and is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value of the source register |
| csr_addr_o | output | 12 | CSR address |
| csr_re_o | output | 1 | CSR read strobe |
| csr_we_o | output | 1 | CSR write strobe |
| csr_wdata_o | output | 32 | Proposed CSR write value before masking |
| csr_rdata_o | output | 32 | Current contents of the addressed CSR (0 if not present) |
| rd_data_o | output | 32 | Previous CSR value for destination writeback |
| rd_we_o | output | 1 | Destination writeback enable |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The assertions check on every cycle the relations between the instruction fields and the strobes: no read for a swap into x0, no write for a set or clear from index zero, no write ever reaching the read-only region, an illegal flag that always silences every strobe, full idleness without valid, and no writeback to x0. The stored results can only be shown by the bench's scenarios. These include the swap, set and clear arithmetic, the writable-bit masking, the immediate zero-extension, persistence across cycles and the reset values. A sweep over every address, operation, index choice and operand pattern covers them, with a read-back probe after every access.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  localparam int XLEN    = 32;
  localparam int ADDR_W  = 12;
  localparam int IDX_W   = 5;
  localparam int NREG    = 4;

  localparam logic [6:0] SYSTEM_OPC = 7'b1110011;

  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_SWAP = 2'b01,
    K_SET  = 2'b10,
    K_CLR  = 2'b11
  } csr_kind_e;

  // Demo bank layout, computed per entry index
  function automatic logic [ADDR_W-1:0] bank_addr(input int i);
    case (i)
      0:       return 12'h300;
      1:       return 12'h305;
      2:       return 12'h340;
      default: return 12'hC00;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] bank_mask(input int i);
    case (i)
      0:       return 32'h0000_1888;
      1:       return 32'hFFFF_FFFC;
      2:       return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] bank_rst(input int i);
    case (i)
      0:       return 32'h0000_0002;
      1:       return 32'h0000_0100;
      2:       return 32'h0000_0000;
      default: return 32'h1234_5678;
    endcase
  endfunction

  function automatic logic addr_is_ro(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ADDR_W-2] == 2'b11;
  endfunction

  // Proposed new value from the operation
  function automatic logic [XLEN-1:0] combine(input csr_kind_e k,
                                              input logic [XLEN-1:0] old_v,
                                              input logic [XLEN-1:0] opnd);
    case (k)
      K_SWAP:  return opnd;
      K_SET:   return old_v | opnd;
      K_CLR:   return old_v & ~opnd;
      default: return old_v;
    endcase
  endfunction

  // Only writable bits take the new value
  function automatic logic [XLEN-1:0] merge_mask(input logic [XLEN-1:0] old_v,
                                                 input logic [XLEN-1:0] new_v,
                                                 input logic [XLEN-1:0] mask);
    return (new_v & mask) | (old_v & ~mask);
  endfunction

  function automatic logic [XLEN-1:0] zext_imm(input logic [IDX_W-1:0] u);
    return {{(XLEN-IDX_W){1'b0}}, u};
  endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_unit_pkg::*;
(
  input  logic [31:0]       insn,
  output logic              is_csr,
  output csr_kind_e         kind,
  output logic              imm_form,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  src_idx,
  output logic [IDX_W-1:0]  rd_idx
);
  logic [2:0] f3;
  logic       opc_hit;

  assign f3       = insn[14:12];
  assign opc_hit  = (insn[6:0] == SYSTEM_OPC);
  assign addr     = insn[31:20];
  assign src_idx  = insn[19:15];
  assign rd_idx   = insn[11:7];
  assign imm_form = f3[2];

  always_comb begin
    kind   = K_NONE;
    is_csr = 1'b0;
    if (opc_hit && (f3[1:0] != 2'b00)) begin
      kind   = csr_kind_e'(f3[1:0]);
      is_csr = 1'b1;
    end
  end
endmodule

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_unit_pkg::*;
(
  input  logic             valid,
  input  logic             is_csr,
  input  csr_kind_e        kind,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             hit,
  input  logic             ro_addr,
  output logic             active,
  output logic             read_intent,
  output logic             write_intent,
  output logic             illegal,
  output logic             re,
  output logic             we,
  output logic             rd_we
);
  logic is_swap;

  assign active       = valid && is_csr;
  assign is_swap      = (kind == K_SWAP);
  // Side effects depend on indices and immediate only, never on data
  assign write_intent = is_swap || (src_idx != '0);
  assign read_intent  = !is_swap || (rd_idx != '0);
  assign illegal      = active && (!hit || (write_intent && ro_addr));
  assign re           = active && read_intent && !illegal;
  assign we           = active && write_intent && !illegal;
  assign rd_we        = active && (rd_idx != '0) && !illegal;
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_unit_pkg::*;
#(
  parameter int N = NREG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata,
  output logic              hit
);
  logic [XLEN-1:0] regs_q [N];
  logic [N-1:0]    sel;

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] A = bank_addr(g);
    localparam logic [XLEN-1:0]   M = bank_mask(g);
    localparam logic [XLEN-1:0]   V = bank_rst(g);

    assign sel[g] = (addr == A);

    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= V;
      else if (we && sel[g])
        regs_q[g] <= merge_mask(regs_q[g], wdata, M);
    end
  end

  assign hit = |sel;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) rdata = rdata | regs_q[i];
  end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  input  logic [31:0] rs1_val_i,
  output logic [11:0] csr_addr_o,
  output logic        csr_re_o,
  output logic        csr_we_o,
  output logic [31:0] csr_wdata_o,
  output logic [31:0] csr_rdata_o,
  output logic [31:0] rd_data_o,
  output logic        rd_we_o,
  output logic        illegal_o
);
  logic              is_csr, imm_form, hit, active;
  logic              read_intent, write_intent;
  csr_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  src_idx, rd_idx;
  logic [XLEN-1:0]   operand, rdata;

  csr_decode u_dec (
    .insn(insn_i), .is_csr(is_csr), .kind(kind), .imm_form(imm_form),
    .addr(addr), .src_idx(src_idx), .rd_idx(rd_idx)
  );

  csr_ctrl u_ctl (
    .valid(valid_i), .is_csr(is_csr), .kind(kind), .src_idx(src_idx),
    .rd_idx(rd_idx), .hit(hit), .ro_addr(addr_is_ro(addr)),
    .active(active), .read_intent(read_intent), .write_intent(write_intent),
    .illegal(illegal_o), .re(csr_re_o), .we(csr_we_o), .rd_we(rd_we_o)
  );

  assign operand     = imm_form ? zext_imm(src_idx) : rs1_val_i;
  assign csr_wdata_o = combine(kind, rdata, operand);
  assign csr_addr_o  = addr;
  assign csr_rdata_o = rdata;
  assign rd_data_o   = rdata;

  csr_bank #(.N(NREG)) u_bank (
    .clk(clk), .rst(rst), .addr(addr), .we(csr_we_o),
    .wdata(csr_wdata_o), .rdata(rdata), .hit(hit)
  );
endmodule

// File: rtl/csr_access_chk.sv
module csr_access_chk
  import csr_unit_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        valid_i,
  input logic [31:0] insn_i,
  input logic [11:0] csr_addr_o,
  input logic        csr_re_o,
  input logic        csr_we_o,
  input logic        rd_we_o,
  input logic        illegal_o
);
  logic sys;
  assign sys = valid_i && (insn_i[6:0] == SYSTEM_OPC);

  a_r5_swap_rd0_noread: assert property (@(posedge clk) disable iff (rst)
    sys && insn_i[13:12] == 2'b01 && insn_i[11:7] == 5'd0 |-> !csr_re_o);

  a_r6_src0_nowrite: assert property (@(posedge clk) disable iff (rst)
    sys && insn_i[13] && insn_i[19:15] == 5'd0 |-> !csr_we_o);

  a_r8_ro_never_written: assert property (@(posedge clk) disable iff (rst)
    csr_we_o |-> csr_addr_o[11:10] != 2'b11);

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !csr_we_o && !csr_re_o && !rd_we_o);

  a_r10_idle_without_valid: assert property (@(posedge clk) disable iff (rst)
    !valid_i |-> !csr_we_o && !csr_re_o && !rd_we_o && !illegal_o);

  a_r2_no_wb_to_x0: assert property (@(posedge clk) disable iff (rst)
    rd_we_o |-> insn_i[11:7] != 5'd0);
endmodule

bind csr_access_unit csr_access_chk u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
  .csr_addr_o(csr_addr_o), .csr_re_o(csr_re_o), .csr_we_o(csr_we_o),
  .rd_we_o(rd_we_o), .illegal_o(illegal_o)
);

// File: tb/tb_csr_access_unit.sv
`timescale 1ns/1ps
module tb_csr_access_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] rs1_val_i = '0;
  logic [11:0] csr_addr_o;
  logic        csr_re_o, csr_we_o, rd_we_o, illegal_o;
  logic [31:0] csr_wdata_o, csr_rdata_o, rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  csr_access_unit dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
    .rs1_val_i(rs1_val_i), .csr_addr_o(csr_addr_o), .csr_re_o(csr_re_o),
    .csr_we_o(csr_we_o), .csr_wdata_o(csr_wdata_o), .csr_rdata_o(csr_rdata_o),
    .rd_data_o(rd_data_o), .rd_we_o(rd_we_o), .illegal_o(illegal_o)
  );

  // Independent model of the demo bank
  logic [11:0] m_addr [4] = '{12'h300, 12'h305, 12'h340, 12'hC00};
  logic [31:0] m_mask [4] = '{32'h0000_1888, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'h0};
  logic [31:0] m_init [4] = '{32'h0000_0002, 32'h0000_0100, 32'h0, 32'h1234_5678};
  logic [31:0] m_val  [4];

  function automatic int find(input logic [11:0] a);
    for (int i = 0; i < 4; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_val[i] = m_init[i];
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                     input logic [2:0] f3, input logic [4:0] rd);
    return {a, s, f3, rd, 7'b1110011};
  endfunction

  // Drive at negedge, check after settling; write commits at next posedge
  task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] r);
    @(negedge clk);
    valid_i = v; insn_i = w; rs1_val_i = r;
    #1;
  endtask

  // Read back with a set from x0 into x1: no write, pure read
  task automatic probe(input logic [11:0] a, input string req);
    int k;
    k = find(a);
    drive(1'b1, mk(a, 5'd0, 3'b010, 5'd1), 32'hFFFF_FFFF);
    chk(csr_we_o == 1'b0, "R6 probe no write", {31'b0, csr_we_o}, 32'd0);
    if (k >= 0)
      chk(rd_data_o == m_val[k] && rd_we_o, req, rd_data_o, m_val[k]);
  endtask

  task automatic run_op(input logic [11:0] a, input logic [2:0] f3,
                        input logic [4:0] rd, input logic [4:0] src,
                        input logic [31:0] val);
    int k;
    bit sw, wi, ri, ill, hit, ro;
    logic [31:0] opnd, old, nv;
    k   = find(a);
    hit = (k >= 0);
    ro  = (a[11:10] == 2'b11);
    sw  = (f3[1:0] == 2'b01);
    wi  = sw || (src != 0);
    ri  = !sw || (rd != 0);
    ill = !hit || (wi && ro);
    old = hit ? m_val[k] : 32'h0;
    opnd = f3[2] ? {27'b0, src} : val;
    case (f3[1:0])
      2'b01:   nv = opnd;
      2'b10:   nv = old | opnd;
      default: nv = old & ~opnd;
    endcase
    drive(1'b1, mk(a, src, f3, rd), val);
    chk(illegal_o == ill, hit ? "R8 illegal flag" : "R9 illegal flag",
        {31'b0, illegal_o}, {31'b0, ill});
    chk(csr_re_o == (ri && !ill), "R5 read strobe", {31'b0, csr_re_o},
        {31'b0, ri && !ill});
    chk(csr_we_o == (wi && !ill), f3[2] ? "R7 write strobe" : "R6 write strobe",
        {31'b0, csr_we_o}, {31'b0, wi && !ill});
    chk(rd_we_o == (rd != 0 && !ill), "R2 writeback enable", {31'b0, rd_we_o},
        {31'b0, rd != 0 && !ill});
    if (rd != 0 && !ill)
      chk(rd_data_o == old, "R2 old value", rd_data_o, old);
    if (wi && !ill) begin
      chk(csr_wdata_o == nv, f3[2] ? "R7 immediate operand" : "R3 write value",
          csr_wdata_o, nv);
      m_val[k] = (nv & m_mask[k]) | (old & ~m_mask[k]);
    end
    if (hit) probe(a, "R4 stored value after access");
  endtask

  initial begin
    logic [11:0] addrs [5] = '{12'h300, 12'h305, 12'h340, 12'hC00, 12'h7C0};
    logic [2:0]  f3s [6]   = '{3'b001, 3'b010, 3'b011, 3'b101, 3'b110, 3'b111};
    logic [4:0]  rds [2]   = '{5'd0, 5'd5};
    logic [4:0]  srcs [3]  = '{5'd0, 5'd3, 5'd17};
    logic [31:0] vals [3]  = '{32'h0, 32'hFFFF_FFFF, 32'h5A5A_0F0F};
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11: reset values
    for (int i = 0; i < 4; i++) probe(m_addr[i], "R11 reset value");

    // R1: non-CSR words are ignored
    drive(1'b1, {12'h340, 5'd3, 3'b001, 5'd5, 7'b0110011}, 32'hAAAA_AAAA);
    chk(!csr_we_o && !csr_re_o && !illegal_o && !rd_we_o, "R1 foreign opcode",
        {28'b0, csr_we_o, csr_re_o, illegal_o, rd_we_o}, 32'h0);
    drive(1'b1, mk(12'h340, 5'd3, 3'b100, 5'd5), 32'hAAAA_AAAA);
    chk(!csr_we_o && !csr_re_o && !illegal_o && !rd_we_o, "R1 unused funct3",
        {28'b0, csr_we_o, csr_re_o, illegal_o, rd_we_o}, 32'h0);
    probe(12'h340, "R1 no change after ignored word");

    // R10: valid low performs nothing
    drive(1'b0, mk(12'h340, 5'd3, 3'b001, 5'd5), 32'hCAFE_F00D);
    chk(!csr_we_o && !csr_re_o && !illegal_o && !rd_we_o, "R10 idle without valid",
        {28'b0, csr_we_o, csr_re_o, illegal_o, rd_we_o}, 32'h0);
    probe(12'h340, "R10 no write without valid");

    // Near-exhaustive sweep
    foreach (addrs[ai]) foreach (f3s[fi]) foreach (rds[ri])
      foreach (srcs[si]) foreach (vals[vi])
        run_op(addrs[ai], f3s[fi], rds[ri], srcs[si], vals[vi]);

    // R6: nonzero index holding zero still writes, unchanged value
    run_op(12'h305, 3'b010, 5'd4, 5'd9, 32'h0);

    // R11: mid-run reset restores initial contents
    run_op(12'h340, 3'b001, 5'd2, 5'd8, 32'h1357_9BDF);
    @(negedge clk); valid_i = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    for (int i = 0; i < 4; i++) probe(m_addr[i], "R11 value after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule